// File: doc/BRIEF.md
# NAND command and address sequencer

This block turns one host register write into the opening of a NAND flash operation on an 8-bit bus. The write's address lines carry a command descriptor and its 32-bit data carries up to four address bytes. A separate 8-bit cycle-zero register supplies a fifth, leading address byte when one is needed. The block plays out a command latch cycle with the first opcode, then the requested address latch cycles, then an optional second command latch cycle. It drives the command latch, address latch, write strobe, eight chip enables and the I/O byte.

While a sequence runs, `busy` is high. The host polls it before it issues the next descriptor. When the last latch cycle has finished, `cmd_done` pulses for one clock. If the descriptor asked for a data phase, `data_req` pulses with it so that a separate transfer engine can take over. The transfer itself and any ECC are outside this block.

There is no back-pressure on the descriptor port. A descriptor is taken only when the block is enabled and idle. A write at any other time is dropped. If it arrived because the block was busy, that is recorded in `overrun`.

Top module: `nand_cmd_seq`

## Requirements
- R1: An accepted descriptor first drives one latch cycle with `nand_cle`=1, `nand_ale`=0 and `nand_io` equal to descriptor bits 9:2.
- R2: Descriptor bits 21:19 give the address-cycle count n. For n from 1 to 4, n latch cycles follow the first opcode with `nand_ale`=1 and `nand_cle`=0, carrying `cmd_wdata` bits 7:0, then 15:8, 23:16 and 31:24, in that order.
- R3: For n=5, the address phase sends the cycle-zero byte first (its value before the accepting edge), then the four data bytes least significant first. A count of 6 or 7 behaves exactly as 5.
- R4: For n=0, no address latch cycle is produced.
- R5: When descriptor bit 18 is 1, one more latch cycle with `nand_cle`=1 carries descriptor bits 17:10 after the last address cycle. When bit 18 is 0, no such cycle is sent.
- R6: Each latch cycle holds `nand_we_n` low for T clocks and then high for T clocks. T is `we_hold` sampled at acceptance, with 0 treated as 1. `nand_cle`, `nand_ale` and `nand_io` are stable through the whole cycle, including the rising edge of `nand_we_n`.
- R7: While busy, exactly the chip enable with index equal to descriptor bits 24:22 is low. At all other times every bit of `nand_ce_n` is high.
- R8: `busy` rises in the cycle after acceptance and stays high for exactly 2·T·S cycles, where S is the number of latch cycles. `cmd_done` is high for the single cycle in which `busy` has just fallen.
- R9: A descriptor write while busy is ignored: the running sequence is unchanged and no second sequence starts. It sets `overrun`, which stays set until reset.
- R10: While `ctrl_en` is 0, all chip enables are high and descriptor writes are ignored without setting `overrun`. Dropping `ctrl_en` during a sequence ends it on the next edge without `cmd_done`.
- R11: `data_req` pulses together with `cmd_done` only when descriptor bit 25 is 1. `data_write` shows descriptor bit 26 (1 for write, 0 for read) of the last accepted descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Block enable; 0 forces idle |
| we_hold | input | 4 | Write-strobe half period T in clocks (0 means 1) |
| cmd_we | input | 1 | Descriptor write strobe |
| cmd_sel | input | 25 | Descriptor, taken from write address bits 26:2 |
| cmd_wdata | input | 32 | Packed address bytes, least significant first |
| cyc0_we | input | 1 | Cycle-zero register write strobe |
| cyc0_wdata | input | 8 | Cycle-zero byte |
| busy | output | 1 | Sequence in progress (host-visible busy bit) |
| cmd_done | output | 1 | One-cycle completion pulse |
| overrun | output | 1 | Sticky: descriptor written while busy |
| data_req | output | 1 | Data phase requested, pulses with cmd_done |
| data_write | output | 1 | Direction of last descriptor's data phase |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_ce_n | output | 8 | Active-low chip enables |
| nand_io | output | 8 | I/O byte |

## Verification
A wrong step index or a wrong byte selection shows at the very next rising edge of `nand_we_n`. The latched CLE/ALE/I/O triple at that edge then differs from the list computed for the descriptor. A half-period counter that is off shows within one latch cycle as a low run of the wrong length, and it also changes the busy length by 2·S per miscounted clock. Chip-enable decode errors appear in the first busy cycle. Completion and overrun faults appear one edge after the cause, as a missing or doubled `cmd_done` or as a second sequence that never should have started.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int ADR_MAX    = 5;
  localparam int WORD_BYTES = 4;
  localparam int STEP_W     = 3;

  typedef struct packed {
    logic       dir_wr;
    logic       dat_en;
    logic [2:0] csel;
    logic [2:0] acnt;
    logic       op2_en;
    logic [7:0] op2;
    logic [7:0] op1;
  } nseq_desc_t;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_CMD  = 2'd1,
    SLOT_ADR  = 2'd2
  } slot_kind_e;

  function automatic nseq_desc_t unpack_desc(input logic [26:2] a);
    nseq_desc_t d;
    d.op1    = a[9:2];
    d.op2    = a[17:10];
    d.op2_en = a[18];
    d.acnt   = (a[21:19] > 3'd5) ? 3'd5 : a[21:19];
    d.csel   = a[24:22];
    d.dat_en = a[25];
    d.dir_wr = a[26];
    return d;
  endfunction
endpackage

// File: rtl/nand_desc_unpack.sv
module nand_desc_unpack
  import nand_seq_pkg::*;
(
  input  logic [26:2]                  cmd_sel,
  input  logic [8*WORD_BYTES-1:0]      wdata,
  input  logic [7:0]                   cyc0,
  output nseq_desc_t                   desc,
  output logic [ADR_MAX-1:0][7:0]      adr_bytes,
  output logic [STEP_W-1:0]            slot_total
);
  assign desc = unpack_desc(cmd_sel);

  // Five-cycle form: cycle-zero byte leads, data word shifts up one slot.
  for (genvar k = 0; k < ADR_MAX; k++) begin : g_byte
    if (k == 0) begin : g_first
      assign adr_bytes[k] = (desc.acnt == 3'd5) ? cyc0 : wdata[7:0];
    end else if (k < WORD_BYTES) begin : g_mid
      assign adr_bytes[k] = (desc.acnt == 3'd5) ? wdata[8*(k-1) +: 8]
                                                : wdata[8*k +: 8];
    end else begin : g_last
      assign adr_bytes[k] = wdata[8*(k-1) +: 8];
    end
  end

  assign slot_total = STEP_W'(1) + desc.acnt + STEP_W'(desc.op2_en);
endmodule

// File: rtl/nand_we_timer.sv
module nand_we_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] hold,
  output logic          we_low,
  output logic          slot_end
);
  logic [TW-1:0] cnt_q;
  logic          high_q;
  logic          half_end;

  assign half_end = (cnt_q == hold - TW'(1));
  assign we_low   = run & ~high_q;
  assign slot_end = run & high_q & half_end;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else if (half_end) begin
      cnt_q  <= '0;
      high_q <= ~high_q;
    end else begin
      cnt_q <= cnt_q + TW'(1);
    end
  end
endmodule

// File: rtl/nand_slot_mux.sv
module nand_slot_mux
  import nand_seq_pkg::*;
(
  input  logic                     run,
  input  nseq_desc_t               desc,
  input  logic [ADR_MAX-1:0][7:0]  adr_bytes,
  input  logic [STEP_W-1:0]        step,
  output logic                     cle,
  output logic                     ale,
  output logic [7:0]               io
);
  slot_kind_e kind;
  logic [7:0] adr_pick;

  always_comb begin
    adr_pick = '0;
    for (int k = 0; k < ADR_MAX; k++) begin
      if (step == STEP_W'(k + 1)) adr_pick = adr_bytes[k];
    end
  end

  always_comb begin
    kind = SLOT_IDLE;
    io   = '0;
    if (run) begin
      if (step == '0) begin
        kind = SLOT_CMD;
        io   = desc.op1;
      end else if (step <= desc.acnt) begin
        kind = SLOT_ADR;
        io   = adr_pick;
      end else begin
        kind = SLOT_CMD;
        io   = desc.op2;
      end
    end
  end

  assign cle = (kind == SLOT_CMD);
  assign ale = (kind == SLOT_ADR);
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int TW  = 4,
  parameter int NCE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_en,
  input  logic [TW-1:0]   we_hold,
  input  logic            cmd_we,
  input  logic [26:2]     cmd_sel,
  input  logic [31:0]     cmd_wdata,
  input  logic            cyc0_we,
  input  logic [7:0]      cyc0_wdata,
  output logic            busy,
  output logic            cmd_done,
  output logic            overrun,
  output logic            data_req,
  output logic            data_write,
  output logic            nand_cle,
  output logic            nand_ale,
  output logic            nand_we_n,
  output logic [NCE-1:0]  nand_ce_n,
  output logic [7:0]      nand_io
);
  nseq_desc_t              dec_desc, desc_q;
  logic [ADR_MAX-1:0][7:0] dec_bytes, bytes_q;
  logic [STEP_W-1:0]       dec_total, total_q, step_q;
  logic [TW-1:0]           hold_q;
  logic [7:0]              cyc0_q;
  logic                    busy_q, done_q, ovr_q;
  logic                    accept, we_low, slot_end;

  nand_desc_unpack u_unpack (
    .cmd_sel    (cmd_sel),
    .wdata      (cmd_wdata),
    .cyc0       (cyc0_q),
    .desc       (dec_desc),
    .adr_bytes  (dec_bytes),
    .slot_total (dec_total)
  );

  nand_we_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q),
    .hold     (hold_q),
    .we_low   (we_low),
    .slot_end (slot_end)
  );

  nand_slot_mux u_mux (
    .run       (busy_q),
    .desc      (desc_q),
    .adr_bytes (bytes_q),
    .step      (step_q),
    .cle       (nand_cle),
    .ale       (nand_ale),
    .io        (nand_io)
  );

  assign accept = cmd_we & ctrl_en & ~busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
      cyc0_q  <= '0;
      desc_q  <= '0;
      bytes_q <= '0;
      total_q <= '0;
      step_q  <= '0;
      hold_q  <= TW'(1);
    end else begin
      done_q <= 1'b0;
      if (cyc0_we) cyc0_q <= cyc0_wdata;
      if (cmd_we && ctrl_en && busy_q) ovr_q <= 1'b1;
      if (!ctrl_en) begin
        busy_q <= 1'b0;
      end else if (accept) begin
        busy_q  <= 1'b1;
        desc_q  <= dec_desc;
        bytes_q <= dec_bytes;
        total_q <= dec_total;
        step_q  <= '0;
        hold_q  <= (we_hold == '0) ? TW'(1) : we_hold;
      end else if (slot_end) begin
        if (step_q == total_q - STEP_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + STEP_W'(1);
        end
      end
    end
  end

  for (genvar k = 0; k < NCE; k++) begin : g_ce
    assign nand_ce_n[k] = ~(busy_q && (int'(desc_q.csel) == k));
  end

  assign nand_we_n  = ~we_low;
  assign busy       = busy_q;
  assign cmd_done   = done_q;
  assign overrun    = ovr_q;
  assign data_req   = done_q & desc_q.dat_en;
  assign data_write = desc_q.dir_wr;
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
  parameter int NCE = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctrl_en,
  input logic           busy,
  input logic           cmd_done,
  input logic           overrun,
  input logic           nand_cle,
  input logic           nand_ale,
  input logic           nand_we_n,
  input logic [NCE-1:0] nand_ce_n,
  input logic [7:0]     nand_io
);
  // R7: at most one chip enable active
  a_r7_ce_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));

  // R7: idle bus is quiet
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&nand_ce_n) && !nand_cle && !nand_ale && nand_we_n);

  // R1: command and address latch never together
  a_r1_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R6: bus held across the strobe's rising edge
  a_r6_hold_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(nand_we_n)) |-> $stable(nand_io) && $stable(nand_cle) && $stable(nand_ale));

  // R6: bus held through the low phase
  a_r6_stable_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !nand_we_n && $past(busy) && !$past(nand_we_n)) |-> $stable(nand_io));

  // R8: completion follows a busy period
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !busy && $past(busy));

  // R8: completion is one cycle wide
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  // R9: overrun is sticky
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R10: disable forces idle
  a_r10_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !busy);
endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(.NCE(NCE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_en   (ctrl_en),
  .busy      (busy),
  .cmd_done  (cmd_done),
  .overrun   (overrun),
  .nand_cle  (nand_cle),
  .nand_ale  (nand_ale),
  .nand_we_n (nand_we_n),
  .nand_ce_n (nand_ce_n),
  .nand_io   (nand_io)
);

// File: tb/nand_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module nand_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_en = 1'b1;
  logic [3:0]  we_hold = 4'd2;
  logic        cmd_we = 1'b0;
  logic [26:2] cmd_sel = '0;
  logic [31:0] cmd_wdata = '0;
  logic        cyc0_we = 1'b0;
  logic [7:0]  cyc0_wdata = '0;
  logic        busy, cmd_done, overrun, data_req, data_write;
  logic        nand_cle, nand_ale, nand_we_n;
  logic [7:0]  nand_ce_n, nand_io;

  always #2.5 clk = ~clk;

  nand_cmd_seq dut_i (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  logic [9:0] log_q [0:2047];
  int nlog = 0, busy_cyc = 0, done_cnt = 0, dreq_cnt = 0;
  int exp_t = 1, exp_cs = 0, lowrun = 0;
  logic prev_we = 1'b1;
  logic [9:0] ex [0:7];
  int S = 0;

  // Monitor: strobe lengths, chip enables, latched slots
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (busy) begin
        busy_cyc++;
        if (nand_ce_n !== ~(8'h01 << exp_cs)) begin
          bad++; $display("FAIL R7 ce_n=%h exp=%h", nand_ce_n, ~(8'h01 << exp_cs));
        end
      end else if (nand_ce_n !== 8'hff) begin
        bad++; $display("FAIL R7 idle ce_n=%h exp=ff", nand_ce_n);
      end
      if (cmd_done) done_cnt++;
      if (data_req) dreq_cnt++;
      if (!nand_we_n) lowrun++;
      else if (!prev_we) begin
        total++;
        if (lowrun != exp_t) begin
          bad++; $display("FAIL R6 low run=%0d exp=%0d", lowrun, exp_t);
        end
        lowrun = 0;
        log_q[nlog % 2048] = {nand_cle, nand_ale, nand_io};
        nlog++;
      end
      prev_we = nand_we_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [26:2] mk(input logic [7:0] op1, input logic [7:0] op2,
      input bit v2, input int ac, input int cs, input bit den, input bit wr);
    logic [26:2] a;
    a = '0;
    a[9:2] = op1; a[17:10] = op2; a[18] = v2;
    a[21:19] = 3'(ac); a[24:22] = 3'(cs); a[25] = den; a[26] = wr;
    return a;
  endfunction

  task automatic build(input logic [26:2] a, input logic [31:0] d, input logic [7:0] c0);
    int n;
    n = int'(a[21:19]);
    if (n > 5) n = 5;
    S = 0;
    ex[S] = {2'b10, a[9:2]}; S++;
    if (n == 5) begin
      ex[S] = {2'b01, c0}; S++;
      for (int k = 0; k < 4; k++) begin ex[S] = {2'b01, d[8*k +: 8]}; S++; end
    end else begin
      for (int k = 0; k < n; k++) begin ex[S] = {2'b01, d[8*k +: 8]}; S++; end
    end
    if (a[18]) begin ex[S] = {2'b10, a[17:10]}; S++; end
  endtask

  task automatic issue(input logic [26:2] a, input logic [31:0] d, input logic [7:0] c0, input int t);
    @(negedge clk);
    we_hold = 4'(t); cyc0_we = 1'b1; cyc0_wdata = c0;
    @(negedge clk);
    cyc0_we = 1'b0;
    exp_t = (t == 0) ? 1 : t;
    exp_cs = int'(a[24:22]);
    cmd_sel = a; cmd_wdata = d; cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic run_cmd(input logic [26:2] a, input logic [31:0] d, input logic [7:0] c0, input int t);
    int base, b0, d0, r0, te;
    build(a, d, c0);
    base = nlog; b0 = busy_cyc; d0 = done_cnt; r0 = dreq_cnt;
    te = (t == 0) ? 1 : t;
    issue(a, d, c0, t);
    chk(busy === 1'b1, "R8 busy after accept", busy, 1);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(nlog - base == S, "R2 slot count", nlog - base, S);
    for (int k = 0; k < S && k < nlog - base; k++) begin
      if (k == 0) chk(log_q[(base+k) % 2048] == ex[k], "R1 first opcode", log_q[(base+k) % 2048], ex[k]);
      else if (ex[k][9]) chk(log_q[(base+k) % 2048] == ex[k], "R5 second opcode", log_q[(base+k) % 2048], ex[k]);
      else if (int'(a[21:19]) >= 5) chk(log_q[(base+k) % 2048] == ex[k], "R3 five-cycle address", log_q[(base+k) % 2048], ex[k]);
      else chk(log_q[(base+k) % 2048] == ex[k], "R2 address byte", log_q[(base+k) % 2048], ex[k]);
    end
    if (a[21:19] == 3'd0) chk(nlog - base == 1 + int'(a[18]), "R4 no address", nlog - base, 1 + int'(a[18]));
    chk(busy_cyc - b0 == 2*te*S, "R8 busy length", busy_cyc - b0, 2*te*S);
    chk(done_cnt - d0 == 1, "R8 done pulses", done_cnt - d0, 1);
    chk(dreq_cnt - r0 == int'(a[25]), "R11 data_req", dreq_cnt - r0, int'(a[25]));
    chk(data_write == a[26], "R11 data_write", data_write, a[26]);
  endtask

  initial begin
    int i;
    int base, d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && cmd_done == 0 && overrun == 0, "R8 reset status", {busy, cmd_done, overrun}, 0);
    chk(nand_ce_n == 8'hff && nand_we_n == 1, "R7 reset ce/we", {nand_ce_n, nand_we_n}, 9'h1ff);
    chk(nand_cle == 0 && nand_ale == 0, "R1 reset latches", {nand_cle, nand_ale}, 0);

    // Sweep: every count, with and without second opcode, three timings
    i = 0;
    for (int ac = 0; ac < 8; ac++)
      for (int v2 = 0; v2 < 2; v2++)
        for (int t = 1; t < 4; t++) begin
          run_cmd(mk(8'(8'h10 + 3*i), 8'(8'hA0 + i), v2[0], ac, i % 8, i[1], i[2]),
                  32'h0403_0201 + 32'(i) * 32'h1357_9bdf, 8'(8'hC0 ^ i), t);
          i++;
        end
    // R6: zero hold treated as one
    run_cmd(mk(8'h70, 8'hE0, 1'b1, 5, 6, 1'b1, 1'b1), 32'hdead_beef, 8'h5a, 0);

    // R10: disabled writes ignored, no overrun
    @(negedge clk); ctrl_en = 1'b0;
    base = nlog;
    issue(mk(8'h33, 8'h44, 1'b1, 2, 1, 1'b0, 1'b0), 32'h0, 8'h0, 2);
    repeat (4) @(negedge clk);
    chk(busy == 0 && nlog == base, "R10 disabled write ignored", busy, 0);
    chk(overrun == 0, "R10 no overrun when disabled", overrun, 0);
    chk(nand_ce_n == 8'hff, "R10 ce high when disabled", nand_ce_n, 8'hff);
    ctrl_en = 1'b1;

    // R10: abort during the first slot's high phase
    d0 = done_cnt;
    issue(mk(8'h21, 8'h31, 1'b1, 4, 3, 1'b1, 1'b0), 32'h1122_3344, 8'h0, 3);
    repeat (3) @(negedge clk);
    ctrl_en = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R10 abort clears busy", busy, 0);
    chk(nand_ce_n == 8'hff, "R10 abort releases ce", nand_ce_n, 8'hff);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0, "R10 no done on abort", done_cnt - d0, 0);
    ctrl_en = 1'b1;
    repeat (2) @(negedge clk);

    // R9: write while busy dropped, sticky overrun
    build(mk(8'h90, 8'h00, 1'b0, 2, 2, 1'b0, 1'b1), 32'h0000_bbaa, 8'h0);
    base = nlog; d0 = done_cnt;
    issue(mk(8'h90, 8'h00, 1'b0, 2, 2, 1'b0, 1'b1), 32'h0000_bbaa, 8'h0, 2);
    cmd_sel = mk(8'hF1, 8'hF2, 1'b1, 5, 7, 1'b1, 1'b0); cmd_wdata = 32'hffff_ffff; cmd_we = 1'b1;
    @(negedge clk); cmd_we = 1'b0;
    chk(overrun == 1, "R9 overrun set", overrun, 1);
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(nlog - base == S, "R9 only first command ran", nlog - base, S);
    for (int k = 0; k < S && k < nlog - base; k++)
      chk(log_q[(base+k) % 2048] == ex[k], "R9 first command intact", log_q[(base+k) % 2048], ex[k]);
    chk(done_cnt - d0 == 1 && busy == 0, "R9 single completion", done_cnt - d0, 1);
    chk(overrun == 1, "R9 overrun sticky", overrun, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule